// File: doc/BRIEF.md
# Per-Priority Pause Request Generator

This block watches the fill level of a small set of ingress headroom buffers and decides when the port should ask its link partner to stop sending. Each of eight switch priorities is steered to one receive buffer by a programmable table. Every buffer carries a size, a lossless flag and a pair of hysteresis thresholds, all counted in 96-byte cells. Cell arrivals and departures come in tagged with a priority. The block turns them into per-buffer occupancy, applies the thresholds, and produces an eight-bit vector of per-priority pause requests plus one link-wide pause request.

Each buffer runs a two-state machine. In `ST_FLOWING`, the transition *congest* moves it to `ST_HALTED` when the buffer is lossless and the updated occupancy exceeds its XOFF level. In `ST_HALTED`, the transition *relieve* moves it back to `ST_FLOWING` when the updated occupancy drops below XON, when it is at or below a threshold shared by XON and XOFF, or when the buffer is marked lossy. Occupancy and state change on the same clock edge. Request outputs are combinational from the states, the map and the enables.

The block also reports the headroom that a lossless buffer needs for a given MTU. This is twice the propagation-delay allowance plus the MTU rounded up to whole cells.

Top module: `pfc_pause_gen`

## Requirements
- R1: After reset all occupancies are zero, every buffer is in `ST_FLOWING`, `pfc_req` and `link_pause_req` are 0, and priority p maps to buffer p mod NUM_BUF.
- R2: A cycle with both an arrival and a departure on the same buffer leaves its occupancy unchanged. Occupancy never goes below zero and never goes above the buffer size.
- R3: When a lossless buffer's occupancy becomes greater than its XOFF level, the request bit of every priority mapped to it rises at the clock edge that applies the arrival.
- R4: A halted buffer keeps its requests while occupancy is at or above XON, and drops them at the edge where occupancy falls below XON.
- R5: When XON equals XOFF, the request is set while occupancy is above the threshold and cleared at or below it.
- R6: A buffer whose lossless flag is 0 produces no request, whatever its occupancy, and this takes effect without waiting for a clock.
- R7: `pfc_req` bit p is set only if `pfc_tx_en` bit p is 1. The mask is applied combinationally.
- R8: `cfg_err` is 1 exactly when `link_pause_en` is 1 and `pfc_tx_en` is non-zero.
- R9: A map write changes only the entries whose `map_wr_mask` bit is 1. Entry p sits at `map_wr_data[2p+1:2p]`.
- R10: `link_pause_req` is 1 when `link_pause_en` is 1 and any lossless buffer is halted.
- R11: `headroom_cells` equals 2 x DELAY_CELLS plus ceil(`mtu_bytes` / 96). DELAY_CELLS defaults to 612.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | One cell arrives this cycle |
| enq_prio | input | 3 | Priority of the arriving cell |
| deq_valid | input | 1 | One cell leaves this cycle |
| deq_prio | input | 3 | Priority of the departing cell |
| map_wr | input | 1 | Write strobe for the priority-to-buffer table |
| map_wr_mask | input | 8 | Per-priority update enables |
| map_wr_data | input | 16 | New buffer index per priority, 2 bits each |
| buf_lossless | input | 4 | Lossless flag per buffer |
| buf_size | input | 64 | Buffer size in cells, 16 bits per buffer |
| buf_xoff | input | 64 | XOFF level in cells, 16 bits per buffer |
| buf_xon | input | 64 | XON level in cells, 16 bits per buffer |
| pfc_tx_en | input | 8 | Per-priority request enable |
| link_pause_en | input | 1 | Link-wide pause enable |
| mtu_bytes | input | 16 | MTU used for the headroom figure |
| pfc_req | output | 8 | Per-priority pause request |
| link_pause_req | output | 1 | Link-wide pause request |
| cfg_err | output | 1 | Link-wide and per-priority pause enabled together |
| headroom_cells | output | 16 | Required lossless headroom in cells |

## Verification
The assertions assume that buffer sizes and thresholds stay fixed while cells are counted, and that XON does not exceed XOFF. The occupancy-step and threshold-crossing checks rely on those settings being static. The stimulus loads every threshold and size once, before reset is released, and afterwards changes only the lossless flags, the enables and the map. The bench also never signals a departure from a buffer that a correct design would hold at zero, except in the one vector that exercises the zero floor.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic {
        ST_FLOWING = 1'b0,
        ST_HALTED  = 1'b1
    } gate_state_e;

    localparam int unsigned CELL_BYTES = 96;

    function automatic int unsigned bytes_to_cells(input int unsigned nbytes);
        return (nbytes + CELL_BYTES - 1) / CELL_BYTES;
    endfunction
endpackage

// File: rtl/pfc_prio_map.sv
module pfc_prio_map #(
    parameter int NUM_PRIO = 8,
    parameter int NUM_BUF  = 4,
    localparam int BUF_W   = $clog2(NUM_BUF)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [NUM_PRIO-1:0]       wr_mask,
    input  logic [NUM_PRIO*BUF_W-1:0] wr_data,
    output logic [NUM_PRIO*BUF_W-1:0] map_flat
);
    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_flat[p*BUF_W +: BUF_W] <= BUF_W'(p % NUM_BUF);
            else if (wr && wr_mask[p])
                map_flat[p*BUF_W +: BUF_W] <= wr_data[p*BUF_W +: BUF_W];
        end
    end

    // R9: without a write strobe the table holds
    assert_map_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(map_flat));
endmodule

// File: rtl/pfc_buf_tracker.sv
module pfc_buf_tracker
    import pfc_pkg::*;
#(
    parameter int CELL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              lossless,
    input  logic [CELL_W-1:0] size,
    input  logic [CELL_W-1:0] xoff,
    input  logic [CELL_W-1:0] xon,
    output logic              halted
);
    logic [CELL_W-1:0] occ, occ_nxt;
    gate_state_e       st, st_nxt;

    always_comb begin
        occ_nxt = occ;
        unique case ({inc, dec})
            2'b10:   if (occ < size) occ_nxt = occ + 1'b1;
            2'b01:   if (occ != '0)  occ_nxt = occ - 1'b1;
            default: occ_nxt = occ;
        endcase
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_FLOWING:
                if (lossless && occ_nxt > xoff) st_nxt = ST_HALTED;
            ST_HALTED:
                if (!lossless || occ_nxt < xon || (xon == xoff && occ_nxt <= xon))
                    st_nxt = ST_FLOWING;
            default: st_nxt = ST_FLOWING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_FLOWING;
            occ <= '0;
        end else begin
            st  <= st_nxt;
            occ <= occ_nxt;
        end
    end

    always_comb halted = lossless && (st == ST_HALTED);

    // R2: occupancy moves by at most one cell per cycle
    assert_occ_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != $past(occ)) |-> (occ == $past(occ) + CELL_W'(1) || occ == $past(occ) - CELL_W'(1)));
    // R3: entering the halted state implies occupancy above XOFF
    assert_halt_above_xoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_HALTED) |-> (occ > xoff));
    // R4: leaving while lossless implies occupancy reached the release level
    assert_release_at_xon_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st == ST_HALTED) && $past(lossless)) |-> (occ < xon || (xon == xoff && occ <= xon)));
    // R6: a lossy buffer never reports halted
    assert_lossy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lossless |-> !halted);
endmodule

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen
    import pfc_pkg::*;
#(
    parameter int NUM_PRIO    = 8,
    parameter int NUM_BUF     = 4,
    parameter int CELL_W      = 16,
    parameter int DELAY_CELLS = 612,
    localparam int PRIO_W     = $clog2(NUM_PRIO),
    localparam int BUF_W      = $clog2(NUM_BUF)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    input  logic [PRIO_W-1:0]         enq_prio,
    input  logic                      deq_valid,
    input  logic [PRIO_W-1:0]         deq_prio,
    input  logic                      map_wr,
    input  logic [NUM_PRIO-1:0]       map_wr_mask,
    input  logic [NUM_PRIO*BUF_W-1:0] map_wr_data,
    input  logic [NUM_BUF-1:0]        buf_lossless,
    input  logic [NUM_BUF*CELL_W-1:0] buf_size,
    input  logic [NUM_BUF*CELL_W-1:0] buf_xoff,
    input  logic [NUM_BUF*CELL_W-1:0] buf_xon,
    input  logic [NUM_PRIO-1:0]       pfc_tx_en,
    input  logic                      link_pause_en,
    input  logic [15:0]               mtu_bytes,
    output logic [NUM_PRIO-1:0]       pfc_req,
    output logic                      link_pause_req,
    output logic                      cfg_err,
    output logic [CELL_W-1:0]         headroom_cells
);
    logic [NUM_PRIO*BUF_W-1:0] map_flat;
    logic [NUM_BUF-1:0]        halted;
    logic [BUF_W-1:0]          enq_buf, deq_buf;

    pfc_prio_map #(.NUM_PRIO(NUM_PRIO), .NUM_BUF(NUM_BUF)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (map_wr),
        .wr_mask  (map_wr_mask),
        .wr_data  (map_wr_data),
        .map_flat (map_flat)
    );

    always_comb begin
        enq_buf = map_flat[enq_prio*BUF_W +: BUF_W];
        deq_buf = map_flat[deq_prio*BUF_W +: BUF_W];
    end

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        pfc_buf_tracker #(.CELL_W(CELL_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (enq_valid && enq_buf == BUF_W'(b)),
            .dec      (deq_valid && deq_buf == BUF_W'(b)),
            .lossless (buf_lossless[b]),
            .size     (buf_size[b*CELL_W +: CELL_W]),
            .xoff     (buf_xoff[b*CELL_W +: CELL_W]),
            .xon      (buf_xon[b*CELL_W +: CELL_W]),
            .halted   (halted[b])
        );
    end

    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_req
        always_comb pfc_req[p] = pfc_tx_en[p] && halted[map_flat[p*BUF_W +: BUF_W]];
    end

    always_comb begin
        link_pause_req = link_pause_en && (|halted);
        cfg_err        = link_pause_en && (|pfc_tx_en);
        headroom_cells = CELL_W'(2 * DELAY_CELLS + bytes_to_cells({16'b0, mtu_bytes}));
    end

    // R7: a request never appears on a disabled priority
    assert_tx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pfc_req & ~pfc_tx_en) == '0);
    // R10: the link request needs the link enable
    assert_link_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        link_pause_req |-> link_pause_en);
    // R1: nothing is requested in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (pfc_req == '0 && !link_pause_req));
endmodule

// File: tb/sim_pfc_pause_gen.sv
module sim_pfc_pause_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        enq_valid = 0, deq_valid = 0, map_wr = 0, link_pause_en = 0;
    logic [2:0]  enq_prio = 0, deq_prio = 0;
    logic [7:0]  map_wr_mask = 0, pfc_tx_en = 0;
    logic [15:0] map_wr_data = 0, mtu_bytes = 16'd1500;
    logic [3:0]  buf_lossless = 4'hF;
    logic [63:0] buf_size, buf_xoff, buf_xon;
    logic [7:0]  pfc_req;
    logic        link_pause_req, cfg_err;
    logic [15:0] headroom_cells;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pfc_pause_gen u0 (.*);

    // {enq_v, enq_p[2:0], deq_v, deq_p[2:0], expected pfc_req}
    localparam logic [15:0] VEC [12] = '{
        {1'b0,3'd0,1'b1,3'd0,8'h00},  // R2 floor at zero
        {1'b1,3'd0,1'b0,3'd0,8'h00},
        {1'b1,3'd4,1'b0,3'd0,8'h00},
        {1'b1,3'd0,1'b0,3'd0,8'h00},
        {1'b1,3'd0,1'b1,3'd4,8'h00},  // R2 net zero
        {1'b1,3'd0,1'b0,3'd0,8'h00},  // at XOFF, not above
        {1'b1,3'd4,1'b0,3'd0,8'h11},  // R3 above XOFF
        {1'b0,3'd0,1'b1,3'd0,8'h11},  // R4 hold
        {1'b0,3'd0,1'b1,3'd0,8'h11},
        {1'b0,3'd0,1'b1,3'd0,8'h11},  // at XON, still held
        {1'b0,3'd0,1'b1,3'd0,8'h00},  // R4 below XON
        {1'b1,3'd1,1'b0,3'd0,8'h00}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ev, input logic [2:0] ep, input logic dv, input logic [2:0] dp);
        enq_valid = ev; enq_prio = ep; deq_valid = dv; deq_prio = dp;
        @(posedge clk); #1;
        enq_valid = 0; deq_valid = 0;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        buf_size = {16'd6, 16'd10, 16'd10, 16'd10};
        buf_xoff = {16'd4, 16'd3,  16'd4,  16'd4};
        buf_xon  = {16'd2, 16'd3,  16'd2,  16'd2};
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        pfc_tx_en = 8'hFF;
        #1;
        check("R1 pfc_req", 16'(pfc_req), 16'h00);
        check("R1 link", 16'(link_pause_req), 16'h0);
        pfc_tx_en = 8'h00;
        #1 check("R8 cfg_err off", 16'(cfg_err), 16'h0);
        pfc_tx_en = 8'hFF;

        for (int i = 0; i < 12; i++) begin
            step(VEC[i][15], VEC[i][14:12], VEC[i][11], VEC[i][10:8]);
            check($sformatf("R3/R4/R2 vec%0d", i), 16'(pfc_req), 16'(VEC[i][7:0]));
        end

        // buf0 occ 1 -> 5
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
        check("R3 refill", 16'(pfc_req), 16'h11);
        pfc_tx_en = 8'h01; #1;
        check("R7 mask", 16'(pfc_req), 16'h01);
        pfc_tx_en = 8'h00; #1;
        check("R7 all off", 16'(pfc_req), 16'h00);
        link_pause_en = 1; #1;
        check("R10 link", 16'(link_pause_req), 16'h1);
        check("R8 no err", 16'(cfg_err), 16'h0);
        pfc_tx_en = 8'h01; #1;
        check("R8 err", 16'(cfg_err), 16'h1);
        link_pause_en = 0; pfc_tx_en = 8'hFF; #1;
        check("R8 cleared", 16'(cfg_err), 16'h0);

        buf_lossless = 4'hE; #1;
        check("R6 lossy immediate", 16'(pfc_req), 16'h00);
        link_pause_en = 1; #1;
        check("R6 R10 lossy link", 16'(link_pause_req), 16'h0);
        link_pause_en = 0;
        step(0, 0, 0, 0);
        check("R6 lossy held", 16'(pfc_req), 16'h00);
        buf_lossless = 4'hF; #1;
        check("R6 back lossless", 16'(pfc_req), 16'h00);
        step(0, 0, 0, 0);
        check("R3 re-halt", 16'(pfc_req), 16'h11);

        map_wr = 1; map_wr_mask = 8'h02; map_wr_data = 16'hFFF3;
        step(0, 0, 0, 0);
        map_wr = 0;
        check("R9 masked write", 16'(pfc_req), 16'h13);

        for (int i = 0; i < 3; i++) step(1, 2, 0, 0);
        check("R5 at threshold", 16'(pfc_req), 16'h13);
        step(1, 2, 0, 0);
        check("R5 above", 16'(pfc_req), 16'h57);
        step(0, 0, 1, 6);
        check("R5 back at threshold", 16'(pfc_req), 16'h13);

        for (int i = 0; i < 10; i++) step(1, 3, 0, 0);
        check("R2 fill buf3", 16'(pfc_req), 16'h9B);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 7);
        check("R2 size cap held", 16'(pfc_req), 16'h9B);
        step(0, 0, 1, 7);
        check("R2 size cap release", 16'(pfc_req), 16'h13);

        mtu_bytes = 16'd1500; #1;
        check("R11 1500", headroom_cells, 16'd1240);
        mtu_bytes = 16'd96; #1;
        check("R11 96", headroom_cells, 16'd1225);
        mtu_bytes = 16'd97; #1;
        check("R11 97", headroom_cells, 16'd1226);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule